// File: doc/BRIEF.md
# Interrupt Status and Clear Unit

This unit gathers the event signals of a two-wire serial bus controller into one status word and produces a single interrupt line for the host. Pulse-type events are captured into sticky bits. Two level-type inputs follow the controller's FIFO threshold comparisons. A programmable mask selects which bits can raise the interrupt. Software reads the masked word to see which enabled causes are pending.

Sticky bits are cleared by reads. Each captured event has its own clear address, and one further address clears all captured events at once. When a transmit abort is reported, the controller also supplies a reason word. That word is held until software reads the abort clear address, so the cause stays available after the status bit has been acknowledged. Register access is a simple single-cycle read/write strobe port with combinational read data. The clear takes effect at the clock edge that ends the read.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the raw status reads 0, the mask reads all ones (0xFFF), the abort-reason word reads 0 and `irq_o` is low.
- R2: A one-cycle pulse on `evt_i[i]` sets raw status bit i, and the bit stays set until it is cleared. Bit positions are: 0 RX underflow, 1 RX overflow, 2 TX overflow, 3 read request, 4 TX abort, 5 RX done, 6 activity, 7 stop detect, 8 start detect, 9 general call. Address 0 reads the raw status.
- R3: A read of address 5+i clears only captured bit i, and returns that bit's value before the clear in data bit 0.
- R4: A read of address 4 returns the raw status and clears all ten captured bits.
- R5: Raw bits 10 (TX FIFO at or below threshold) and 11 (RX FIFO above threshold) show the `tx_lvl_i` and `rx_lvl_i` inputs one cycle later. Clear reads have no effect on them.
- R6: Address 1 reads raw AND mask. A write to address 2 sets the mask. A zero mask keeps `irq_o` low and leaves the raw status unchanged.
- R7: `irq_o` is the OR of the masked status, registered once, so it follows the status by one cycle. It is low in the cycle after `ctrl_en_i` is low.
- R8: A TX-abort event loads `abort_reason_i` into the abort word, which reads at address 3. The word is cleared only by a read of address 9 (the TX-abort clear). A clear-all read leaves it intact.
- R9: If a captured event and the clear read for the same bit fall in one cycle, the bit is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_en_i | input | 1 | Controller enable; gates the interrupt |
| evt_i | input | 10 | Single-cycle event pulses for the captured sources |
| tx_lvl_i | input | 1 | TX FIFO threshold level |
| rx_lvl_i | input | 1 | RX FIFO threshold level |
| abort_reason_i | input | ABORT_W | Reason word, valid with the TX-abort pulse |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wr_data_i | input | 12 | Write data (mask) |
| rd_data_o | output | DATA_W | Read data, combinational |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench builds the unit with its defaults: a 16-bit abort word and bus, and a 5-bit address. With these defaults every clear address, the clear-all address and the full 12-bit mask can be reached directly. The same widths let the reason word be checked over its full width, and let a multi-bit status word show that a single clear leaves its neighbours set. The bench also drives an event and its own clear in the same cycle, and moves the level inputs across clear-all reads.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int N_CAPT = 10;
  localparam int N_LVL  = 2;
  localparam int N_SRC  = N_CAPT + N_LVL;

  localparam int B_RX_UNDER = 0;
  localparam int B_RX_OVER  = 1;
  localparam int B_TX_OVER  = 2;
  localparam int B_RD_REQ   = 3;
  localparam int B_TX_ABORT = 4;
  localparam int B_RX_DONE  = 5;
  localparam int B_ACTIVITY = 6;
  localparam int B_STOP     = 7;
  localparam int B_START    = 8;
  localparam int B_GCALL    = 9;
  localparam int B_TX_LVL   = 10;
  localparam int B_RX_LVL   = 11;

  localparam int A_RAW      = 0;
  localparam int A_MASKED   = 1;
  localparam int A_MASK     = 2;
  localparam int A_ABORT    = 3;
  localparam int A_CLR_ALL  = 4;
  localparam int A_CLR_BASE = 5;
endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q_d, q_q;

    // a new event wins over a clear in the same cycle
    always_comb begin
      q_d = q_q;
      if (clr_i[i]) q_d = 1'b0;
      if (set_i[i]) q_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= 1'b0;
      else         q_q <= q_d;
    end

    assign q_o[i] = q_q;

    a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);
    a_r3_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o[i] && !clr_i[i]) |=> q_o[i]);
  end
endmodule

// File: rtl/irq_abort_hold.sv
module irq_abort_hold #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] reason_i,
  input  logic         clr_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_d, word_q;
  logic         word_en;

  assign word_en = load_i | clr_i;

  always_comb begin
    word_d = word_q;
    if (clr_i)  word_d = '0;
    if (load_i) word_d = reason_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign word_o = word_q;

  a_r8_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (word_o == $past(reason_i)));
  a_r8_wipe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !load_i) |=> (word_o == '0));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i) |=> $stable(word_o));
endmodule

// File: rtl/irq_access_decode.sv
module irq_access_decode
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int ABORT_W = 16
) (
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [N_SRC-1:0]   raw_i,
  input  logic [N_SRC-1:0]   masked_i,
  input  logic [N_SRC-1:0]   mask_i,
  input  logic [ABORT_W-1:0] abort_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [N_CAPT-1:0]  clr_o,
  output logic               abort_clr_o,
  output logic               mask_we_o
);
  logic clr_all;

  assign clr_all     = rd_en_i && (addr_i == ADDR_W'(A_CLR_ALL));
  assign abort_clr_o = rd_en_i && (addr_i == ADDR_W'(A_CLR_BASE + B_TX_ABORT));
  assign mask_we_o   = wr_en_i && (addr_i == ADDR_W'(A_MASK));

  for (genvar i = 0; i < N_CAPT; i++) begin : g_clr
    assign clr_o[i] = clr_all || (rd_en_i && (addr_i == ADDR_W'(A_CLR_BASE + i)));
  end

  always_comb begin
    rd_data_o = '0;
    unique case (addr_i)
      ADDR_W'(A_RAW):     rd_data_o[N_SRC-1:0]   = raw_i;
      ADDR_W'(A_MASKED):  rd_data_o[N_SRC-1:0]   = masked_i;
      ADDR_W'(A_MASK):    rd_data_o[N_SRC-1:0]   = mask_i;
      ADDR_W'(A_ABORT):   rd_data_o[ABORT_W-1:0] = abort_i;
      ADDR_W'(A_CLR_ALL): rd_data_o[N_SRC-1:0]   = raw_i;
      default: begin
        for (int i = 0; i < N_CAPT; i++)
          if (addr_i == ADDR_W'(A_CLR_BASE + i)) rd_data_o[0] = raw_i[i];
      end
    endcase
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int ABORT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_en_i,
  input  logic [N_CAPT-1:0]  evt_i,
  input  logic               tx_lvl_i,
  input  logic               rx_lvl_i,
  input  logic [ABORT_W-1:0] abort_reason_i,
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [N_SRC-1:0]   wr_data_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o
);
  logic [N_CAPT-1:0]  capt_q;
  logic [N_CAPT-1:0]  clr_vec;
  logic [N_LVL-1:0]   lvl_q;
  logic [N_SRC-1:0]   raw, masked;
  logic [N_SRC-1:0]   mask_d, mask_q;
  logic [ABORT_W-1:0] abort_word;
  logic               abort_clr, mask_we;
  logic               irq_d, irq_q;

  irq_event_latch #(.N(N_CAPT)) i_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_i),
    .clr_i (clr_vec),
    .q_o   (capt_q)
  );

  irq_abort_hold #(.W(ABORT_W)) i_abort (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (evt_i[B_TX_ABORT]),
    .reason_i(abort_reason_i),
    .clr_i   (abort_clr),
    .word_o  (abort_word)
  );

  irq_access_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ABORT_W(ABORT_W)) i_dec (
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .raw_i      (raw),
    .masked_i   (masked),
    .mask_i     (mask_q),
    .abort_i    (abort_word),
    .rd_data_o  (rd_data_o),
    .clr_o      (clr_vec),
    .abort_clr_o(abort_clr),
    .mask_we_o  (mask_we)
  );

  // level sources are resampled every cycle and never cleared
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= {rx_lvl_i, tx_lvl_i};
  end

  assign raw    = {lvl_q, capt_q};
  assign masked = raw & mask_q;

  assign mask_d = wr_data_i;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '1;
    else if (mask_we) mask_q <= mask_d;
  end

  assign irq_d = ctrl_en_i & (|masked);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  a_r7_off_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en_i |=> !irq_o);
  a_r6_zero_mask_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> !irq_o);
  a_r7_follows_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_en_i && (raw[B_STOP] && mask_q[B_STOP])) |=> irq_o);
  a_r5_level_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (raw[B_RX_LVL:B_TX_LVL] == $past({rx_lvl_i, tx_lvl_i})));
endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  import irq_stat_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_en = 1'b0;
  logic [9:0]  evt = '0;
  logic        tx_lvl = 1'b0, rx_lvl = 1'b0;
  logic [15:0] reason = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [11:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0, fails = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_en_i(ctrl_en), .evt_i(evt),
    .tx_lvl_i(tx_lvl), .rx_lvl_i(rx_lvl), .abort_reason_i(reason),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rdata), .irq_o(irq)
  );

  // monitor: compares each read against the scoreboard head
  always @(negedge clk) begin
    #1;
    if (rd_en && exp_q.size() > 0) begin
      int e; string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (int'(rdata) != e) begin
        fails++;
        $display("FAIL %s addr=%0d actual=0x%0h expected=0x%0h", t, addr, rdata, e);
      end
    end
  end

  task automatic rd(input int a, input int e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = 5'(a);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'(a); wdata = 12'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int bits, input int why);
    @(negedge clk);
    evt = 10'(bits); reason = 16'(why);
    @(negedge clk);
    evt = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    #1;
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(A_RAW, 0, "R1");
    rd(A_MASK, 12'hFFF, "R1");
    rd(A_ABORT, 0, "R1");
    rd(A_MASKED, 0, "R1");

    ctrl_en = 1'b1;
    // R2 / R7 stop event raises the interrupt one cycle after status
    pulse(1 << B_STOP, 0);
    @(negedge clk); chk_irq(1'b1, "R7");
    rd(A_RAW, 12'h080, "R2");
    rd(A_MASKED, 12'h080, "R6");
    rd(A_CLR_BASE + B_STOP, 1, "R3");
    rd(A_RAW, 0, "R3");
    chk_irq(1'b0, "R7");

    // R8 abort reason, survives clear-all, wiped by abort clear
    pulse(1 << B_TX_ABORT, 16'h00A5);
    rd(A_ABORT, 16'h00A5, "R8");
    rd(A_RAW, 12'h010, "R2");
    rd(A_CLR_ALL, 12'h010, "R4");
    rd(A_RAW, 0, "R4");
    rd(A_ABORT, 16'h00A5, "R8");
    rd(A_CLR_BASE + B_TX_ABORT, 0, "R8");
    rd(A_ABORT, 0, "R8");

    // R3 single clear leaves neighbours, R4 clear-all
    pulse((1 << B_RX_OVER) | (1 << B_TX_OVER) | (1 << B_START), 0);
    rd(A_CLR_BASE + B_RX_OVER, 1, "R3");
    rd(A_RAW, 12'h104, "R3");
    rd(A_CLR_ALL, 12'h104, "R4");
    rd(A_RAW, 0, "R4");

    // R6 zero mask
    wr(A_MASK, 0);
    pulse(1 << B_RX_UNDER, 0);
    rd(A_RAW, 12'h001, "R6");
    rd(A_MASKED, 0, "R6");
    chk_irq(1'b0, "R6");
    wr(A_MASK, 12'hFFF);
    @(negedge clk); chk_irq(1'b1, "R7");
    ctrl_en = 1'b0;
    @(negedge clk); chk_irq(1'b0, "R7");
    ctrl_en = 1'b1;
    rd(A_CLR_ALL, 12'h001, "R4");

    // R5 level sources
    tx_lvl = 1'b1;
    rd(A_RAW, 12'h400, "R5");
    rd(A_CLR_ALL, 12'h400, "R5");
    rd(A_RAW, 12'h400, "R5");
    rx_lvl = 1'b1;
    rd(A_RAW, 12'hC00, "R5");
    tx_lvl = 1'b0; rx_lvl = 1'b0;
    rd(A_RAW, 0, "R5");

    // R9 event and its own clear in one cycle
    @(negedge clk);
    evt = 10'(1 << B_GCALL);
    rd_en = 1'b1; addr = 5'(A_CLR_BASE + B_GCALL);
    exp_q.push_back(0); tag_q.push_back("R9");
    @(negedge clk);
    evt = '0; rd_en = 1'b0;
    rd(A_RAW, 12'h200, "R9");
    rd(A_CLR_BASE + B_GCALL, 1, "R3");
    rd(A_RAW, 0, "R9");

    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule